// File: doc/BRIEF.md
# Flash Erase and Erase-Verify Sequencer

This block steps an on-chip flash array through repeated erase and erase-verify passes until a chosen address range reads back fully erased, or until a retry ceiling is reached. The array is split into two banks by address bit 17: the lower bank holds 0x00000 to 0x1FFFF and the upper bank holds 0x20000 to 0x3FFFF. Each bank has its own setup, erase and verify control bits. A shared write-enable bit stays high for the whole operation.

A host pulses `start` with a word-aligned first and last address. The sequencer then raises setup and then the erase pulse for each bank that the range touches. After that it backs out of erase mode, observing minimum settling times, and enters verify mode. At each address it writes an all-ones dummy word and then reads 32 bits back. One word with a zero bit sends the whole range back to erase. A fully clean range, or an exhausted retry budget, ends the run with `done` or `fail`.

All minimum times are given in microseconds and converted to clock cycles from a clock-frequency parameter in MHz. The length of the erase pulse is a separate parameter, given in cycles.

Top module: `fev_seq`

## Requirements
- R1: After reset, every control output (`swe`, `esu`, `ers`, `ev`), `mem_we`, `mem_re`, `busy`, `done` and `fail` is low.
- R2: Bit 0 of `esu`, `ers` and `ev` drives the lower bank and is used when `lo_addr[17]` is 0. Bit 1 drives the upper bank and is used when `hi_addr[17]` is 1. No other bank bit is ever raised.
- R3: `ers` is only high while `esu` is high. After `ers` falls, `esu` stays high for at least 10 µs.
- R4: `ev` rises at least 10 µs after `esu` falls, and `ev` and `esu` are never high together.
- R5: The first dummy write of a pass comes at least 20 µs after `ev` rises. Every dummy write carries 0xFFFFFFFF.
- R6: Each read (`mem_re`) targets the most recently written address and comes at least 2 µs after that write. `mem_rdata` is taken one cycle after `mem_re`.
- R7: Each pass writes addresses from `lo_addr` upward in steps of 4. After a read of all ones it moves on to the next address, and a clean read of `hi_addr` ends the pass as erased.
- R8: A read with any zero bit ends the pass at once. The next round then restarts erase and begins verify again at `lo_addr`.
- R9: At most MAX_ROUNDS (default 60) erase pulses are issued per start. When the last permitted round fails, `fail` rises and `done` does not. `done` and `fail` are never high together, and both hold until the next accepted start.
- R10: After a passing verify, `ev` falls and `swe` falls at least 5 µs later.
- R11: `swe` rises with the accepted start and falls only when `done` or `fail` rises.
- R12: `busy` is high from an accepted start until the end of the run. A `start` that arrives while busy is ignored.
- R13: Each erase pulse on `ers` lasts exactly ERASE_CYC clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a run; taken only when idle |
| lo_addr | input | ADDR_W | First word address of the range |
| hi_addr | input | ADDR_W | Last word address of the range |
| mem_we | output | 1 | Dummy write strobe |
| mem_re | output | 1 | Verify read strobe |
| mem_addr | output | ADDR_W | Address for write and read |
| mem_wdata | output | 32 | Dummy write data, all ones |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_re` |
| swe | output | 1 | Write-enable for the array |
| esu | output | 2 | Per-bank erase setup |
| ers | output | 2 | Per-bank erase pulse |
| ev | output | 2 | Per-bank erase-verify mode |
| busy | output | 1 | Run in progress |
| done | output | 1 | Range verified erased |
| fail | output | 1 | Retry ceiling reached |

## Verification
The case most likely to go wrong is a miscompare that lands on the final address in the final permitted round. There, the end-of-range decision and the retry-ceiling decision fall in the same check cycle, and the run must end in `fail`, not `done`. The bench provokes this with a memory model that keeps the last word unerased for 61 pulses, and expects exactly 60 pulses followed by `fail`. A second run, with a model that clears after exactly 60 pulses, must end in `done`. A scoreboard compares every dummy-write address against a sequence predicted from the rounds, and monitors measure each gap between control edges against its minimum.

// File: rtl/fev_pkg.sv
package fev_pkg;

    localparam int NBANK    = 2;
    localparam int BANK_BIT = 17;
    localparam int DW       = 32;

    typedef enum logic [3:0] {
        S_IDLE, S_SETUP, S_ERASE, S_HOLD, S_REL,
        S_VSET, S_WRITE, S_GAP, S_READ, S_CHECK, S_EXIT
    } fev_state_e;

    typedef struct packed {
        logic             swe;
        logic [NBANK-1:0] esu;
        logic [NBANK-1:0] ers;
        logic [NBANK-1:0] ev;
    } fev_ctrl_t;

    function automatic int us_to_cyc(int us, int mhz);
        return us * mhz;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fev_delay.sv
module fev_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_DELAY_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0)); // R13
endmodule

// File: rtl/fev_walk.sv
module fev_walk #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic [AW-1:0] init_val,
    input  logic          step,
    input  logic [AW-1:0] hi,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] STRIDE = AW'(4);

    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (init) addr <= init_val;
        else if (step) addr <= addr + STRIDE;
    end

    assign last = (addr == hi);
endmodule

// File: rtl/fev_seq.sv
module fev_seq
    import fev_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int CLK_MHZ    = 2,
    parameter int ERASE_CYC  = 16,
    parameter int MAX_ROUNDS = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] lo_addr,
    input  logic [ADDR_W-1:0] hi_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              swe,
    output logic [1:0]        esu,
    output logic [1:0]        ers,
    output logic [1:0]        ev,
    output logic              busy,
    output logic              done,
    output logic              fail
);
    localparam int T10   = us_to_cyc(10, CLK_MHZ);
    localparam int T20   = us_to_cyc(20, CLK_MHZ);
    localparam int T2    = us_to_cyc(2, CLK_MHZ);
    localparam int T5    = us_to_cyc(5, CLK_MHZ);
    localparam int TGAP  = (T2 >= 2) ? T2 - 2 : 0;
    localparam int MAXD  = imax(imax(T10, T20), imax(ERASE_CYC, imax(T5, T2)));
    localparam int TW    = $clog2(MAXD + 1) + 1;
    localparam int RW    = $clog2(MAX_ROUNDS + 1);

    fev_state_e          st, nxt;
    logic [ADDR_W-1:0]   lo_q, hi_q;
    logic [NBANK-1:0]    mask_q;
    logic [RW-1:0]       round;
    logic                passed;
    logic                t_load, t_zero;
    logic [TW-1:0]       t_val;
    logic                w_init, w_step, w_last;
    logic [ADDR_W-1:0]   w_addr;
    logic                rd_clean;
    fev_ctrl_t           ctrl;

    assign rd_clean = (mem_rdata == '1);

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (start)  nxt = S_SETUP;
            S_SETUP: if (t_zero) nxt = S_ERASE;
            S_ERASE: if (t_zero) nxt = S_HOLD;
            S_HOLD:  if (t_zero) nxt = S_REL;
            S_REL:   if (t_zero) nxt = S_VSET;
            S_VSET:  if (t_zero) nxt = S_WRITE;
            S_WRITE:             nxt = S_GAP;
            S_GAP:   if (t_zero) nxt = S_READ;
            S_READ:              nxt = S_CHECK;
            S_CHECK: nxt = (rd_clean && !w_last) ? S_WRITE : S_EXIT;
            S_EXIT:  if (t_zero) nxt = (passed || round == RW'(MAX_ROUNDS)) ? S_IDLE : S_SETUP;
            default:             nxt = S_IDLE;
        endcase
    end

    always_comb begin
        t_load = (nxt != st);
        unique case (nxt)
            S_SETUP: t_val = TW'(T10 - 1);
            S_ERASE: t_val = TW'(ERASE_CYC - 1);
            S_HOLD:  t_val = TW'(T10 - 1);
            S_REL:   t_val = TW'(T10 - 1);
            S_VSET:  t_val = TW'(T20 - 1);
            S_GAP:   t_val = TW'(TGAP);
            S_EXIT:  t_val = TW'(T5 - 1);
            default: t_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            lo_q   <= '0;
            hi_q   <= '0;
            mask_q <= '0;
            round  <= '0;
            passed <= 1'b0;
            done   <= 1'b0;
            fail   <= 1'b0;
        end else begin
            st <= nxt;
            if (st == S_IDLE && start) begin
                lo_q      <= lo_addr;
                hi_q      <= hi_addr;
                mask_q[0] <= ~lo_addr[BANK_BIT];
                mask_q[1] <= hi_addr[BANK_BIT];
                round     <= RW'(1);
                done      <= 1'b0;
                fail      <= 1'b0;
                passed    <= 1'b0;
            end
            if (st == S_CHECK)
                passed <= rd_clean && w_last;
            if (st == S_EXIT && t_zero) begin
                if (passed)                         done  <= 1'b1;
                else if (round == RW'(MAX_ROUNDS))  fail  <= 1'b1;
                else                                round <= round + 1'b1;
            end
        end
    end

    assign w_init = (nxt == S_VSET) && (st != S_VSET);
    assign w_step = (st == S_CHECK) && rd_clean && !w_last;

    fev_delay #(.W(TW)) u_delay (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    fev_walk #(.AW(ADDR_W)) u_walk (
        .clk(clk), .rst(rst), .init(w_init), .init_val(lo_q), .step(w_step),
        .hi(hi_q), .addr(w_addr), .last(w_last)
    );

    always_comb begin
        ctrl.swe = (st != S_IDLE);
        ctrl.esu = (st inside {S_SETUP, S_ERASE, S_HOLD}) ? mask_q : '0;
        ctrl.ers = (st == S_ERASE) ? mask_q : '0;
        ctrl.ev  = (st inside {S_VSET, S_WRITE, S_GAP, S_READ, S_CHECK}) ? mask_q : '0;
    end

    assign swe       = ctrl.swe;
    assign esu       = ctrl.esu;
    assign ers       = ctrl.ers;
    assign ev        = ctrl.ev;
    assign busy      = (st != S_IDLE);
    assign mem_we    = (st == S_WRITE);
    assign mem_re    = (st == S_READ);
    assign mem_addr  = w_addr;
    assign mem_wdata = '1;

    AST_ERS_UNDER_ESU: assert property (@(posedge clk) disable iff (rst)
        (ers & ~esu) == '0); // R3
    AST_EV_ESU_APART: assert property (@(posedge clk) disable iff (rst)
        !((|ev) && (|esu))); // R4
    AST_WE_RE_APART: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re)); // R6
    AST_WALK_BOUND: assert property (@(posedge clk) disable iff (rst)
        (mem_we && lo_q <= hi_q) |-> (mem_addr <= hi_q)); // R7
    AST_ROUND_CAP: assert property (@(posedge clk) disable iff (rst)
        round <= RW'(MAX_ROUNDS)); // R9
    AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && fail)); // R9
    AST_SWE_FALL_END: assert property (@(posedge clk) disable iff (rst)
        $fell(swe) |-> (done || fail)); // R11
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(lo_q) && $stable(hi_q))); // R12
endmodule

// File: tb/fev_seq_test.sv
module fev_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ  = 2;
    localparam int ECYC = 16;
    localparam int MAXR = 60;
    localparam int T10  = 10 * MHZ;
    localparam int T20  = 20 * MHZ;
    localparam int T2   = 2 * MHZ;
    localparam int T5   = 5 * MHZ;

    logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [17:0] lo_addr = '0, hi_addr = '0, mem_addr;
    logic        mem_we, mem_re, swe, busy, done, fail;
    logic [31:0] mem_wdata, mem_rdata = '1;
    logic [1:0]  esu, ers, ev;

    fev_seq #(.ADDR_W(18), .CLK_MHZ(MHZ), .ERASE_CYC(ECYC), .MAX_ROUNDS(MAXR)) uut (
        .clk(clk), .rst(rst), .start(start), .lo_addr(lo_addr), .hi_addr(hi_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .swe(swe), .esu(esu), .ers(ers), .ev(ev),
        .busy(busy), .done(done), .fail(fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0, pulses = 0, need = 0;
    logic [17:0] fail_addr = '0, last_w = '0;
    logic [1:0]  exp_mask = '0;
    logic [17:0] exp_q[$];
    int t_ersr = 0, t_ersf = 0, t_esuf = 0, t_evr = 0, t_evf = 0, t_w = 0;
    bit first_w = 0;
    logic [1:0] p_ers = '0, p_esu = '0, p_ev = '0;
    logic p_swe = 1'b0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: fail_addr reads back unerased until `need` pulses have occurred
    always @(posedge clk)
        if (mem_re)
            mem_rdata <= (pulses < need && mem_addr == fail_addr) ? 32'hFFFF_7FFF : 32'hFFFF_FFFF;

    // monitor: timing checks and scoreboard pop
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (ers != 0 && p_ers == 0) begin
                t_ersr = cyc; pulses++;
                chk(ers == exp_mask, "R2", "ers bank mask", ers, exp_mask);
            end
            if (ers == 0 && p_ers != 0) begin
                chk(cyc - t_ersr == ECYC, "R13", "erase pulse length", cyc - t_ersr, ECYC);
                t_ersf = cyc;
            end
            if (esu == 0 && p_esu != 0) begin
                chk(cyc - t_ersf >= T10, "R3", "ers fall to esu fall", cyc - t_ersf, T10);
                t_esuf = cyc;
            end
            if (ev != 0 && p_ev == 0) begin
                chk(cyc - t_esuf >= T10, "R4", "esu fall to ev rise", cyc - t_esuf, T10);
                chk(ev == exp_mask, "R2", "ev bank mask", ev, exp_mask);
                t_evr = cyc; first_w = 1;
            end
            if (ev == 0 && p_ev != 0) t_evf = cyc;
            if (mem_we) begin
                if (first_w)
                    chk(cyc - t_evr >= T20, "R5", "ev rise to first write", cyc - t_evr, T20);
                first_w = 0; t_w = cyc; last_w = mem_addr;
                chk(mem_wdata == 32'hFFFF_FFFF, "R5", "dummy data", mem_wdata, 32'hFFFF_FFFF);
                if (exp_q.size() == 0)
                    chk(0, "R7", "unexpected write", mem_addr, 0);
                else begin
                    automatic logic [17:0] e = exp_q.pop_front();
                    chk(mem_addr == e, "R7", "write address", mem_addr, e);
                end
            end
            if (mem_re) begin
                chk(mem_addr == last_w, "R6", "read address", mem_addr, last_w);
                chk(cyc - t_w >= T2, "R6", "write to read gap", cyc - t_w, T2);
            end
            if (!swe && p_swe)
                chk(cyc - t_evf >= T5, "R10", "ev fall to swe fall", cyc - t_evf, T5);
        end
        p_ers = ers; p_esu = esu; p_ev = ev; p_swe = swe;
    end

    task automatic push_expected(logic [17:0] lo, logic [17:0] hi, int nd, logic [17:0] fa);
        int nr = (nd < MAXR) ? nd : MAXR;
        for (int r = 1; r <= nr; r++) begin
            logic [17:0] stop = (r < nd) ? fa : hi;
            for (logic [17:0] a = lo; a <= stop; a += 18'd4) exp_q.push_back(a);
        end
    endtask

    task automatic run_case(logic [17:0] lo, logic [17:0] hi, int nd, logic [17:0] fa,
                            logic [1:0] msk, bit exp_ok);
        int nr = (nd < MAXR) ? nd : MAXR;
        need = nd; fail_addr = fa; exp_mask = msk; pulses = 0;
        push_expected(lo, hi, nd, fa);
        @(negedge clk); start = 1'b1; lo_addr = lo; hi_addr = hi;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R12", "busy after start", busy, 1);
        chk(swe == 1'b1, "R11", "swe after start", swe, 1);
        while (!(done || fail)) @(negedge clk);
        chk(done == exp_ok, "R9", "done", done, exp_ok);
        chk(fail == !exp_ok, "R9", "fail", fail, !exp_ok);
        chk(pulses == nr, "R9", "erase pulse count", pulses, nr);
        chk(exp_q.size() == 0, "R8", "writes left unseen", exp_q.size(), 0);
        chk(busy == 1'b0 && swe == 1'b0, "R11", "busy/swe at end", {busy, swe}, 0);
        repeat (3) @(negedge clk);
        chk(done == exp_ok && fail == !exp_ok, "R9", "status held", {done, fail}, {exp_ok, !exp_ok});
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk({swe, esu, ers, ev, mem_we, mem_re, busy, done, fail} == '0, "R1",
            "outputs after reset", {swe, esu, ers, ev, mem_we, mem_re, busy, done, fail}, 0);
        // R2 R7: lower bank only, clean in one round
        run_case(18'h00100, 18'h0010C, 1, 18'h00100, 2'b01, 1'b1);
        // R2 R8: range spanning both banks, third round passes
        run_case(18'h1FFF8, 18'h20004, 3, 18'h20000, 2'b11, 1'b1);
        // R9 R12: upper bank, last word never clears in the final round; ignored start mid-run
        fork
            run_case(18'h30000, 18'h30008, 61, 18'h30008, 2'b10, 1'b0);
            begin
                repeat (300) @(negedge clk);
                start = 1'b1; lo_addr = 18'h00000; hi_addr = 18'h00004;
                @(negedge clk); start = 1'b0;
            end
        join
        // R9: clears exactly on the last permitted round
        run_case(18'h30000, 18'h30008, 60, 18'h30000, 2'b10, 1'b1);
        summary();
        $finish;
    end
endmodule